// File: doc/BRIEF.md
# Master-mode serial shift engine

This block is the bit-level core of a clocked serial controller that acts as bus master. It pops one word at a time from an external transmit queue and drives it out bit by bit on the serial data output, while it samples the serial data input and assembles the received word. Each finished word is handed to an external receive queue with a single-cycle push strobe. Chip select, register decoding and the queues themselves belong to the surrounding logic. Configuration arrives on static control pins that the surrounding logic changes only while `busy` is low.

A word is 8 or 16 bits and can go out most-significant or least-significant bit first. The serial clock has a selectable idle level and a selectable sampling edge. Its half period is a 14-bit count of functional-clock cycles. A receive-only mode clocks words in, with the output line held high, for as long as the receive queue has room. A synchronous soft reset abandons the current word at once.

The controller has three states. `ST_IDLE` waits for a start condition: enabled, not in soft reset, and either transmit data present (transmit-and-receive mode) or receive space present (receive-only mode). `ST_IDLE -> ST_LEAD` fires on that start. `ST_LEAD` is the first half of a bit, with the clock at its idle level. `ST_LEAD -> ST_TRAIL` fires when the half-period timer expires, and the clock moves to its active level. `ST_TRAIL` is the second half of a bit. `ST_TRAIL -> ST_LEAD` fires at the end of any bit but the last. `ST_TRAIL -> ST_IDLE` fires at the end of the last bit. Any state goes to `ST_IDLE` when soft reset is sampled high.

Top module: `spi_shift_engine`

## Requirements
- R1: After `rst_n` is released and before any start, `busy`, `tx_pop` and `rx_push` are 0, `mosi` is 1, and `sck` sits at the idle level of R2.
- R2: While no word is in progress, `sck` equals the inverse of `pol_ctl`: `pol_ctl`=1 gives an idle-low clock and `pol_ctl`=0 gives an idle-high clock.
- R3: With `lsb_first`=1, bit 0 of the word is transferred first. With `lsb_first`=0, the top bit of the word is transferred first. Each received bit is stored at the bit position that was transferred in the same slot.
- R4: With `wide_sel`=1, a word is 16 bits, taken from `tx_data[15:0]`. With `wide_sel`=0, a word is 8 bits, taken from `tx_data[7:0]`, and `rx_data[15:8]` is 0.
- R5: With `pha_ctl`=1, `miso` is sampled on the leading clock edge (idle to active) and `mosi` changes on the trailing edge. With `pha_ctl`=0, `miso` is sampled on the trailing edge and `mosi` changes on the leading edge. In both cases `mosi` is stable at the edge where the receiver samples.
- R6: Each clock half period lasts `half_div` functional-clock cycles. A value of 0 acts as 1.
- R7: With `txrx_sel`=0 (receive-only), `tx_pop` stays 0 and `mosi` stays 1. A new word starts whenever the engine is enabled and `rx_full` is 0, and no new word starts while `rx_full` is 1.
- R8: With `txrx_sel`=1, a word starts only when `tx_empty` is 0, popping exactly one entry with `tx_pop`. While the queue is empty, `sck` makes no edges.
- R9: Clearing `enable` during a word lets that word complete: `busy` stays 1 until its `rx_push`, and no further word starts.
- R10: A cycle with `soft_rst`=1 returns the engine to idle on the next cycle: `busy` low, `sck` at idle level, and no `rx_push` for the abandoned word.
- R11: `rx_push` is a one-cycle pulse in the cycle after the last trailing edge. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous abort to idle |
| enable | input | 1 | Permits new words to start |
| txrx_sel | input | 1 | 1 = transmit and receive, 0 = receive only |
| wide_sel | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| lsb_first | input | 1 | 1 = least significant bit first |
| pol_ctl | input | 1 | 1 = clock idles low, 0 = idles high |
| pha_ctl | input | 1 | 1 = sample on leading edge, 0 = on trailing edge |
| half_div | input | 14 | Clock half period in functional cycles |
| tx_data | input | 16 | Head entry of the transmit queue |
| tx_empty | input | 1 | Transmit queue empty |
| tx_pop | output | 1 | Pops the transmit queue head |
| rx_full | input | 1 | Receive queue full |
| rx_data | output | 16 | Received word, valid with rx_push |
| rx_push | output | 1 | Pushes rx_data into the receive queue |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is in progress |

## Verification
Serial-clock edges appear one cycle after the timer expiry that causes them. Each half period is therefore `half_div` cycles, and a word runs 2·`half_div`·W cycles after the pop. `rx_push` and the fall of `busy` come one cycle after the last trailing-edge expiry, and soft reset shows at the outputs one cycle after it is sampled. The bench acts on and samples everything one time unit after the falling clock edge. A falling-edge monitor detects `sck` transitions, measures their spacing, records `mosi` at the sampling edge and advances the bit that is offered on `miso`. Every check therefore falls in a cycle where the result is already settled.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // a zero divider behaves as one cycle per half period
    assign limit = (half_div == '0) ? ONE : half_div;
    assign tick  = run && (cnt_q == (limit - ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/spi_word_path.sv
module spi_word_path #(
    parameter int MAX_W = 16,
    parameter int MIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAX_W-1:0] load_word,
    input  logic             fill_ones,
    input  logic             wide,
    input  logic             lsb_first,
    input  logic             sample,
    input  logic             advance,
    input  logic             miso,
    output logic             first_bit,
    output logic             cur_bit,
    output logic             next_bit,
    output logic             last_bit,
    output logic [MAX_W-1:0] rx_word
);
    localparam int IDX_W = $clog2(MAX_W);
    localparam logic [IDX_W-1:0] TOP_WIDE   = IDX_W'(MAX_W - 1);
    localparam logic [IDX_W-1:0] TOP_NARROW = IDX_W'(MIN_W - 1);
    localparam logic [IDX_W-1:0] IDX_ONE    = IDX_W'(1);

    logic [MAX_W-1:0] tx_q;
    logic [MAX_W-1:0] rx_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] pos_first;
    logic [IDX_W-1:0] pos_cur;
    logic [IDX_W-1:0] pos_next;
    logic [MAX_W-1:0] word_masked;

    // maps a transfer slot to its bit position within the word
    function automatic logic [IDX_W-1:0] slot_pos(input logic [IDX_W-1:0] slot,
                                                  input logic [IDX_W-1:0] top,
                                                  input logic             lsb);
        return lsb ? slot : (top - slot);
    endfunction

    assign top_idx   = wide ? TOP_WIDE : TOP_NARROW;
    assign pos_first = slot_pos('0, top_idx, lsb_first);
    assign pos_cur   = slot_pos(idx_q, top_idx, lsb_first);
    assign pos_next  = slot_pos(idx_q + IDX_ONE, top_idx, lsb_first);

    assign word_masked = wide ? load_word
                              : {{(MAX_W-MIN_W){1'b0}}, load_word[MIN_W-1:0]};

    assign first_bit = fill_ones ? 1'b1 : word_masked[pos_first];
    assign cur_bit   = tx_q[pos_cur];
    assign next_bit  = tx_q[pos_next];
    assign last_bit  = (idx_q == top_idx);

    // received word including a bit sampled in this very cycle
    always_comb begin
        rx_word = rx_q;
        if (sample) begin
            rx_word[pos_cur] = miso;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            tx_q  <= fill_ones ? '1 : word_masked;
            rx_q  <= '0;
            idx_q <= '0;
        end else begin
            if (sample) begin
                rx_q <= rx_word;
            end
            if (advance) begin
                idx_q <= idx_q + IDX_ONE;
            end
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DIV_W = 14,
    parameter int MAX_W = 16,
    parameter int MIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             enable,
    input  logic             txrx_sel,
    input  logic             wide_sel,
    input  logic             lsb_first,
    input  logic             pol_ctl,
    input  logic             pha_ctl,
    input  logic [DIV_W-1:0] half_div,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             tx_empty,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_push,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             busy
);
    eng_state_t state_q;
    eng_state_t state_d;

    logic idle_level;
    logic late_sample;
    logic start_ok;
    logic tick;
    logic lead_end;
    logic trail_end;
    logic sample_now;
    logic first_bit;
    logic cur_bit;
    logic next_bit;
    logic last_bit;
    logic [MAX_W-1:0] rx_word;

    logic             sck_act_q;
    logic             mosi_q;
    logic             rx_push_q;
    logic [MAX_W-1:0] rx_data_q;

    // the control pins are active-low views of polarity and phase
    assign idle_level  = ~pol_ctl;
    assign late_sample = ~pha_ctl;

    assign start_ok = (state_q == ST_IDLE) && enable && !soft_rst &&
                      (txrx_sel ? !tx_empty : !rx_full);

    assign lead_end   = (state_q == ST_LEAD)  && tick && !soft_rst;
    assign trail_end  = (state_q == ST_TRAIL) && tick && !soft_rst;
    assign sample_now = late_sample ? trail_end : lead_end;

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .half_div (half_div),
        .tick     (tick)
    );

    spi_word_path #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_ok),
        .load_word (tx_data),
        .fill_ones (!txrx_sel),
        .wide      (wide_sel),
        .lsb_first (lsb_first),
        .sample    (sample_now),
        .advance   (trail_end),
        .miso      (miso),
        .first_bit (first_bit),
        .cur_bit   (cur_bit),
        .next_bit  (next_bit),
        .last_bit  (last_bit),
        .rx_word   (rx_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    state_d = last_bit ? ST_IDLE : ST_LEAD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (soft_rst) begin
            state_d = ST_IDLE;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_act_q <= 1'b0;
            mosi_q    <= 1'b1;
            rx_push_q <= 1'b0;
            rx_data_q <= '0;
        end else begin
            rx_push_q <= 1'b0;
            if (soft_rst) begin
                sck_act_q <= 1'b0;
            end else begin
                if (start_ok) begin
                    mosi_q <= first_bit;
                end
                if (lead_end) begin
                    sck_act_q <= 1'b1;
                    if (late_sample) begin
                        mosi_q <= cur_bit;
                    end
                end
                if (trail_end) begin
                    sck_act_q <= 1'b0;
                    if (!late_sample && !last_bit) begin
                        mosi_q <= next_bit;
                    end
                    if (last_bit) begin
                        rx_push_q <= 1'b1;
                        rx_data_q <= rx_word;
                    end
                end
            end
        end
    end

    assign tx_pop  = start_ok && txrx_sel;
    assign sck     = sck_act_q ^ idle_level;
    assign mosi    = mosi_q;
    assign rx_push = rx_push_q;
    assign rx_data = rx_data_q;
    assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
    parameter int DIV_W = 14,
    parameter int MAX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             enable,
    input logic             txrx_sel,
    input logic             pol_ctl,
    input logic             tx_empty,
    input logic             tx_pop,
    input logic             rx_push,
    input logic             sck,
    input logic             mosi,
    input logic             busy
);
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == ~pol_ctl)); // R2

    AST_RXONLY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !txrx_sel |-> !tx_pop); // R7

    AST_RXONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !txrx_sel) |-> mosi); // R7

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (!tx_empty && enable)); // R8

    AST_BUSY_ENDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rx_push || $past(soft_rst))); // R9

    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !rx_push)); // R10

    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push); // R11

    AST_PUSH_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !busy); // R11

endmodule

bind spi_shift_engine spi_shift_engine_chk #(.DIV_W(DIV_W), .MAX_W(MAX_W)) u_chk (.*);

// File: tb/tb_spi_shift_engine.sv
module tb_spi_shift_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        enable = 1'b0;
    logic        txrx_sel = 1'b1;
    logic        wide_sel = 1'b0;
    logic        lsb_first = 1'b0;
    logic        pol_ctl = 1'b1;
    logic        pha_ctl = 1'b1;
    logic [13:0] half_div = 14'd2;
    logic [15:0] tx_data;
    logic        tx_empty;
    logic        tx_pop;
    logic        rx_full = 1'b0;
    logic [15:0] rx_data;
    logic        rx_push;
    logic        sck;
    logic        mosi;
    logic        miso;
    logic        busy;

    always #4 clk = ~clk;

    spi_shift_engine dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .txrx_sel(txrx_sel), .wide_sel(wide_sel), .lsb_first(lsb_first),
        .pol_ctl(pol_ctl), .pha_ctl(pha_ctl), .half_div(half_div),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_data(rx_data), .rx_push(rx_push),
        .sck(sck), .mosi(mosi), .miso(miso), .busy(busy)
    );

    // transmit queue model
    logic [15:0] txq [0:15];
    logic [3:0]  tx_wr = 4'd0;
    logic [3:0]  tx_rd = 4'd0;
    assign tx_empty = (tx_wr == tx_rd);
    assign tx_data  = txq[tx_rd];
    always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 4'd1;

    int checks = 0;
    int fails  = 0;

    // serial-side monitor and responder
    int          k = 0;
    int          edges = 0;
    int          since = 0;
    int          hmin = 1000000;
    int          hmax = 0;
    int          rx_cnt = 0;
    int          zero_seen = 0;
    logic [15:0] mosi_acc = '0;
    logic [15:0] got_rx = '0;
    logic [15:0] slv_word = '0;
    logic        sck_prev = 1'b0;

    function automatic int bpos(input int kk);
        int wd;
        wd = wide_sel ? 16 : 8;
        return lsb_first ? (kk % wd) : (wd - 1 - (kk % wd));
    endfunction

    always_comb miso = slv_word[bpos(k)];

    always @(negedge clk) begin
        if (rst_n && (sck !== sck_prev)) begin
            if (edges > 0) begin
                if (since + 1 < hmin) hmin = since + 1;
                if (since + 1 > hmax) hmax = since + 1;
            end
            edges++;
            since = 0;
            // sampling edge: leading when pha_ctl=1, trailing when pha_ctl=0
            if ((sck != !pol_ctl) == pha_ctl) begin
                mosi_acc[bpos(k)] = mosi;
                if (!mosi) zero_seen++;
                k++;
            end
        end else begin
            since++;
        end
        sck_prev = sck;
        if (rx_push) begin
            got_rx = rx_data;
            rx_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic mon_clear();
        k = 0; edges = 0; since = 0; hmin = 1000000; hmax = 0;
        mosi_acc = '0; zero_seen = 0;
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // R1: reset state
    task automatic t_reset();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 busy", busy, 0);
        check("R1 tx_pop", tx_pop, 0);
        check("R1 rx_push", rx_push, 0);
        check("R1 mosi", mosi, 1);
        check("R1 sck", sck, 0);
    endtask

    // R2: idle clock level follows the polarity pin
    task automatic t_idle_level();
        pol_ctl = 1'b0;
        step();
        check("R2 idle high", sck, 1);
        pol_ctl = 1'b1;
        step();
        check("R2 idle low", sck, 0);
    endtask

    // one word in transmit-and-receive mode
    task automatic t_xfer(input string req, input logic w16, input logic lsb,
                          input logic pol, input logic pha, input logic [13:0] div,
                          input logic [15:0] txw, input logic [15:0] slw);
        int c0;
        int exp_h;
        logic [15:0] msk;
        txrx_sel = 1'b1; wide_sel = w16; lsb_first = lsb;
        pol_ctl = pol; pha_ctl = pha; half_div = div;
        step();
        step();
        mon_clear();
        slv_word = slw;
        msk = w16 ? 16'hFFFF : 16'h00FF;
        exp_h = (div == 0) ? 1 : int'(div);
        txq[tx_wr] = txw;
        tx_wr = tx_wr + 4'd1;
        c0 = rx_cnt;
        enable = 1'b1;
        while (rx_cnt == c0) step();
        enable = 1'b0;
        check({req, " R11 busy low with push"}, busy, 0);
        check({req, " R3/R4 mosi word"}, mosi_acc & msk, txw & msk);
        check({req, " R3/R4 rx word"}, got_rx, slw & msk);
        check({req, " R5 bit count"}, k, w16 ? 16 : 8);
        check({req, " R6 min half period"}, hmin, exp_h);
        check({req, " R6 max half period"}, hmax, exp_h);
        step();
        check({req, " R11 push one cycle"}, rx_push, 0);
        check({req, " R2 idle after word"}, sck, !pol);
    endtask

    // R7: receive-only streaming with queue-full stop
    task automatic t_rx_only();
        int c0;
        int c1;
        txrx_sel = 1'b0; wide_sel = 1'b0; lsb_first = 1'b0;
        pol_ctl = 1'b1; pha_ctl = 1'b1; half_div = 14'd1;
        step();
        step();
        mon_clear();
        slv_word = 16'h00C6;
        c0 = rx_cnt;
        enable = 1'b1;
        while (rx_cnt < c0 + 3) step();
        rx_full = 1'b1;
        while (busy) step();
        c1 = rx_cnt;
        repeat (40) step();
        check("R7 no word while full", rx_cnt, c1);
        check("R7 busy low while full", busy, 0);
        check("R7 mosi held high", zero_seen, 0);
        check("R7 rx word", got_rx, 16'h00C6);
        check("R7 tx untouched", tx_empty, 1);
        enable = 1'b0;
        rx_full = 1'b0;
        step();
    endtask

    // R8: transmit mode waits for data
    task automatic t_tx_wait();
        txrx_sel = 1'b1; half_div = 14'd1;
        step();
        step();
        mon_clear();
        enable = 1'b1;
        repeat (40) step();
        check("R8 no clock edges", edges, 0);
        check("R8 not busy", busy, 0);
        enable = 1'b0;
        step();
    endtask

    // R9: clearing enable mid-word
    task automatic t_enable_drop();
        int c0;
        txrx_sel = 1'b1; wide_sel = 1'b1; pol_ctl = 1'b1; pha_ctl = 1'b1;
        half_div = 14'd2; lsb_first = 1'b0;
        step();
        mon_clear();
        txq[tx_wr] = 16'h1234; tx_wr = tx_wr + 4'd1;
        txq[tx_wr] = 16'h5678; tx_wr = tx_wr + 4'd1;
        c0 = rx_cnt;
        enable = 1'b1;
        while (!busy) step();
        repeat (5) step();
        enable = 1'b0;
        step();
        check("R9 busy held", busy, 1);
        while (rx_cnt == c0) step();
        check("R9 word sent", mosi_acc, 16'h1234);
        repeat (40) step();
        check("R9 single word", rx_cnt, c0 + 1);
        check("R9 second left queued", tx_empty, 0);
        tx_wr = tx_rd;
        step();
    endtask

    // R10: soft reset mid-word
    task automatic t_soft_reset();
        int c0;
        txrx_sel = 1'b1; wide_sel = 1'b0; pol_ctl = 1'b0; pha_ctl = 1'b0;
        half_div = 14'd5;
        step();
        step();
        txq[tx_wr] = 16'h0081; tx_wr = tx_wr + 4'd1;
        c0 = rx_cnt;
        enable = 1'b1;
        repeat (14) step();
        check("R10 busy before abort", busy, 1);
        soft_rst = 1'b1;
        enable = 1'b0;
        step();
        soft_rst = 1'b0;
        check("R10 busy cleared", busy, 0);
        check("R10 sck idle", sck, 1);
        repeat (60) step();
        check("R10 no push", rx_cnt, c0);
    endtask

    initial begin
        t_reset();
        t_idle_level();
        t_xfer("mode0 msb8", 1'b0, 1'b0, 1'b1, 1'b1, 14'd3, 16'h00C3, 16'h005A);
        t_xfer("lsb8",       1'b0, 1'b1, 1'b1, 1'b1, 14'd2, 16'h002D, 16'h00B4);
        t_xfer("wide msb",   1'b1, 1'b0, 1'b1, 1'b1, 14'd2, 16'hA53C, 16'h1E87);
        t_xfer("late idle-high", 1'b0, 1'b0, 1'b0, 1'b0, 14'd1, 16'h0096, 16'h0069);
        t_xfer("late idle-low",  1'b0, 1'b0, 1'b1, 1'b0, 14'd4, 16'h00F0, 16'h000F);
        t_xfer("early idle-high", 1'b0, 1'b1, 1'b0, 1'b1, 14'd2, 16'hFF71, 16'hAA8E);
        t_xfer("div zero",   1'b0, 1'b0, 1'b1, 1'b1, 14'd0, 16'h0055, 16'h00AA);
        t_xfer("wide lsb late", 1'b1, 1'b1, 1'b0, 1'b0, 14'd6, 16'h8001, 16'h7FFE);
        t_rx_only();
        t_tx_wait();
        t_enable_drop();
        t_soft_reset();
        report();
    end

endmodule